// File: doc/BRIEF.md
# PWM D/A Converter Channel

This block is one channel of a pulse-width-modulated digital-to-analog converter. It holds a 14-bit level word and a 14-bit free-running counter. The counter advances once on each cycle in which the resolution tick `tickEn` is high. One full counter period is a conversion period. It is divided into base cycles of either 64 or 256 ticks, selected by a carrier bit. In every base cycle the output goes high for a coarse number of ticks, taken from the upper bits of the level word. In some base cycles the high time is one tick longer. The lower bits of the level word choose those base cycles through a bit-reversed comparison, which spreads the extra ticks evenly. Over a full conversion period, the high time in ticks equals the level word. An external low-pass filter turns the pulse train into an analog voltage.

Software reaches the block through two 16-bit slots. A view bit chooses what each slot shows. Slot 0 shows either the level word or the control word. Slot 1 shows the counter in the control view. The carrier bit and the view bit always occupy bits 1:0 of slot 0. A 12-bit mode clears the two lowest level bits and drops them from the fine comparison. While the counter runs, a new level, carrier or mode takes effect only at the next counter wrap.

Top module: `pwmdac_channel`

## Requirements
- R1: After reset the block is in the control view with the carrier bit at 1, output enable, run and 12-bit mode at 0, the counter at 0 and `pwmOut` low. Slot 0 reads 0x0003, and the level word is 0x3FFF.
- R2: The view bit is `wrData[0]` of a slot-0 write, and the carrier bit is `wrData[1]`. Both are written by every slot-0 write in either view. In the level view (view 0), slot 0 reads {level[13:0], carrier, view}, slot 1 reads 0, and slot-1 writes are ignored. In the control view (view 1), slot 0 reads {outEnable, run, mode12, 11'b0, carrier, view}, and slot 1 reads {counter, 2'b00}. A slot-1 write loads the counter from `wrData[15:2]`.
- R3: While run is 1, the counter increments on each `tickEn` cycle and wraps from 0x3FFF to 0. While run is 0 it holds. A counter load takes priority over the increment.
- R4: With carrier 0 (64 ticks per base cycle), let pos = counter[5:0] and idx = counter[13:6]. Let extra = 1 when level[7:0] > bitreverse8(idx). The output is high when pos < level[13:8] + extra.
- R5: With carrier 1 (256 ticks per base cycle), let pos = counter[7:0] and idx = counter[13:8]. Let extra = 1 when level[5:0] > bitreverse6(idx). The output is high when pos < level[13:6] + extra.
- R6: For an in-range level word, the number of high ticks over one full 16384-tick conversion period equals the level word.
- R7: A level word below 0x0100 with carrier 0, or below 0x0040 with carrier 1, holds the output constantly low.
- R8: Setting 12-bit mode clears level bits 1:0. While the mode is set, those bits are written as 0, and the fine comparison ignores the two lowest bits of both the level word and the reversed index.
- R9: While run is 1, the level word, carrier and mode used for the output are reloaded only at a counter wrap. While run is 0, they follow the registers on every cycle.
- R10: With output enable at 0, `pwmOut` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Resolution tick strobe, one counter step per high cycle |
| wrEn | input | 1 | Register write strobe |
| regSlot | input | 1 | Slot select, 0 or 1 |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected slot, combinational |
| pwmOut | output | 1 | Pulse output |

## Verification
The assertions assume that `tickEn` and the write inputs are stable around the clock edge. They also assume that a counter load and an increment may fall in the same cycle, with the load winning. The stimulus changes every input only on the falling edge. It stops the counter before reloading it, and the one mid-period write is a level or carrier change while the counter runs. The counter is always started from 0, so every tick of each full conversion period falls under a known phase and the output can be predicted arithmetically.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  parameter int CNT_W = 14;

  // Configuration and strobes handed from the register file to the datapath.
  typedef struct packed {
    logic             cntLoad;
    logic [CNT_W-1:0] cntVal;
    logic             run;
    logic             outEn;
    logic             mode12;
    logic             carSel;
    logic [CNT_W-1:0] level;
  } dpCmd_t;
endpackage

// File: rtl/pwmdac_ctrl.sv
module pwmdac_ctrl
  import pwmdac_pkg::*;
#(
  parameter int FINE_IGN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               regSlot,
  input  logic [CNT_W+1:0]   wrData,
  input  logic [CNT_W-1:0]   cnt,
  output logic [CNT_W+1:0]   rdData,
  output dpCmd_t             cmd
);
  localparam int BUS_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'((1 << FINE_IGN) - 1);

  logic [CNT_W-1:0] levelReg;
  logic             carSel;
  logic             viewSel;
  logic             outEn;
  logic             runEn;
  logic             mode12;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelReg <= '1;
      carSel   <= 1'b1;
      viewSel  <= 1'b1;
      outEn    <= 1'b0;
      runEn    <= 1'b0;
      mode12   <= 1'b0;
    end else if (wrEn && !regSlot) begin
      carSel  <= wrData[1];
      viewSel <= wrData[0];
      if (!viewSel) begin
        levelReg <= wrData[BUS_W-1:2] & ~(mode12 ? LOW_MASK : '0);
      end else begin
        outEn  <= wrData[BUS_W-1];
        runEn  <= wrData[BUS_W-2];
        mode12 <= wrData[BUS_W-3];
        if (wrData[BUS_W-3]) levelReg <= levelReg & ~LOW_MASK;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (!regSlot) begin
      if (!viewSel) rdData = {levelReg, carSel, viewSel};
      else rdData = {outEn, runEn, mode12, {(BUS_W-5){1'b0}}, carSel, viewSel};
    end else if (viewSel) begin
      rdData = {cnt, 2'b00};
    end
  end

  always_comb begin
    cmd.cntLoad = wrEn && regSlot && viewSel;
    cmd.cntVal  = wrData[BUS_W-1:2];
    cmd.run     = runEn;
    cmd.outEn   = outEn;
    cmd.mode12  = mode12;
    cmd.carSel  = carSel;
    cmd.level   = levelReg;
  end

  AST_MODE12_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    mode12 |-> ((levelReg & LOW_MASK) == '0)); // R8
endmodule

// File: rtl/pwmdac_datapath.sv
module pwmdac_datapath
  import pwmdac_pkg::*;
#(
  parameter int SHORT_POS_W = 6,
  parameter int LONG_POS_W  = 8,
  parameter int FINE_IGN    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dpCmd_t           cmd,
  output logic [CNT_W-1:0] cnt,
  output logic             pwmOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] actLevel;
  logic             actCar;
  logic             actMode;
  logic             wrap;
  logic [1:0]       lvl;

  assign wrap = cmd.run && tickEn && !cmd.cntLoad && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.cntLoad) begin
      cnt <= cmd.cntVal;
    end else if (cmd.run && tickEn) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Shadow copy: follows the registers while idle, reloads at wrap while running.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLevel <= '1;
      actCar   <= 1'b1;
      actMode  <= 1'b0;
    end else if (!cmd.run || wrap) begin
      actLevel <= cmd.level;
      actCar   <= cmd.carSel;
      actMode  <= cmd.mode12;
    end
  end

  for (genvar v = 0; v < 2; v++) begin : g_car
    localparam int P = (v == 0) ? SHORT_POS_W : LONG_POS_W;
    localparam int F = CNT_W - P;
    logic [P-1:0] pos;
    logic [P-1:0] coarse;
    logic [F-1:0] idx;
    logic [F-1:0] fine;
    logic [F-1:0] rev;
    logic         extra;
    logic         lvlV;
    always_comb begin
      pos    = cnt[P-1:0];
      idx    = cnt[CNT_W-1:P];
      coarse = actLevel[CNT_W-1:F];
      fine   = actLevel[F-1:0];
      for (int i = 0; i < F; i++) rev[i] = idx[F-1-i];
      if (actMode) extra = (fine >> FINE_IGN) > (rev >> FINE_IGN);
      else extra = fine > rev;
      lvlV = (coarse != '0) && ({1'b0, pos} < ({1'b0, coarse} + {{P{1'b0}}, extra}));
    end
    assign lvl[v] = lvlV;
  end

  assign pwmOut = cmd.outEn && (actCar ? lvl[1] : lvl[0]);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && tickEn && !cmd.cntLoad && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (cnt == '0)); // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cntLoad |=> (cnt == $past(cmd.cntVal))); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && !wrap) |=> ($stable(actLevel) && $stable(actCar) && $stable(actMode))); // R9
endmodule

// File: rtl/pwmdac_channel.sv
module pwmdac_channel
  import pwmdac_pkg::*;
#(
  parameter int SHORT_POS_W = 6,
  parameter int LONG_POS_W  = 8,
  parameter int FINE_IGN    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic         regSlot,
  input  logic [15:0]  wrData,
  output logic [15:0]  rdData,
  output logic         pwmOut
);
  dpCmd_t           cmd;
  logic [CNT_W-1:0] cnt;

  pwmdac_ctrl #(.FINE_IGN(FINE_IGN)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSlot(regSlot),
    .wrData(wrData), .cnt(cnt), .rdData(rdData), .cmd(cmd)
  );

  pwmdac_datapath #(
    .SHORT_POS_W(SHORT_POS_W), .LONG_POS_W(LONG_POS_W), .FINE_IGN(FINE_IGN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd), .cnt(cnt), .pwmOut(pwmOut)
  );
endmodule

// File: tb/pwmdac_channel_bench.sv
module pwmdac_channel_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b1;
  logic        wrEn = 1'b0;
  logic        regSlot = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        pwmOut;
  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwmdac_channel u_pwmdac_channel (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .regSlot(regSlot),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit slot, logic [15:0] v);
    @(negedge clk);
    wrEn = 1'b1; regSlot = slot; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int expOut(int k, int d, bit car, bit m12, bit oe);
    int p = car ? 8 : 6;
    int f = 14 - p;
    int kk = k & 16'h3FFF;
    int pos = kk & ((1 << p) - 1);
    int idx = kk >> p;
    int coarse = d >> f;
    int fine = d & ((1 << f) - 1);
    int rev = 0;
    for (int i = 0; i < f; i++) if (idx & (1 << i)) rev |= 1 << (f - 1 - i);
    if (m12) begin fine = fine >> 2; rev = rev >> 2; end
    return (oe && coarse != 0 && pos < coarse + (fine > rev ? 1 : 0)) ? 1 : 0;
  endfunction

  // Stop, clear the counter, program level/carrier/mode, verify readback, start.
  task automatic setup(int d, bit car, bit m12, bit oe);
    int dm = m12 ? (d & 16'h3FFC) : d;
    wr(0, {13'b0, car, 1'b1});
    wr(0, {13'b0, car, 1'b1});
    wr(1, 16'h0000);
    wr(0, {14'b0, car, 1'b0});
    wr(0, {d[13:0], car, 1'b1});
    wr(0, {oe, 1'b0, m12, 11'b0, car, 1'b1});
    wr(0, {oe, 1'b0, m12, 11'b0, car, 1'b0});
    chk("R8 level readback", rdData, (dm << 2) | (car << 1));
    wr(1, 16'hBEEF);
    regSlot = 1'b1;
    #1 chk("R2 slot1 in level view", rdData, 0);
    wr(0, {d[13:0], car, 1'b1});
    regSlot = 1'b1;
    #1 chk("R2 slot1 write ignored", rdData, 0);
    wr(0, {oe, 1'b1, m12, 11'b0, car, 1'b1});
  endtask

  task automatic sweep(string req, int d, bit car, bit m12, bit oe, int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      chk(req, pwmOut, expOut(k, d, car, m12, oe));
      highs += pwmOut;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regSlot = 1'b0;
    #1 chk("R1 control after reset", rdData, 16'h0003);
    chk("R1 output after reset", pwmOut, 0);
    regSlot = 1'b1;
    #1 chk("R1 counter after reset", rdData, 0);
    wr(0, 16'h0002);
    regSlot = 1'b0;
    #1 chk("R1 level after reset", rdData, 16'hFFFE);

    // R4 R6: 64-tick carrier, full period
    setup(16'h1A5B, 0, 0, 1);
    sweep("R4 carrier64 wave", 16'h1A5B, 0, 0, 1, 16384, h);
    chk("R6 carrier64 high total", h, 16'h1A5B);
    regSlot = 1'b1;
    #1 chk("R3 counter wrapped", rdData, 0);
    repeat (37) @(negedge clk);
    chk("R3 counter advance", rdData, 37 << 2);

    // R5 R6: 256-tick carrier
    setup(16'h2C37, 1, 0, 1);
    sweep("R5 carrier256 wave", 16'h2C37, 1, 0, 1, 16384, h);
    chk("R6 carrier256 high total", h, 16'h2C37);

    // R8: 12-bit mode, low bits written as 1 are dropped
    setup(16'h0F3F, 0, 1, 1);
    sweep("R8 mode12 wave", 16'h0F3C, 0, 1, 1, 16384, h);
    chk("R8 mode12 high total", h, 16'h0F3C);

    // R7: out-of-range levels and the lowest legal level
    setup(16'h00FF, 0, 0, 1);
    sweep("R7 below range carrier64", 16'h00FF, 0, 0, 1, 2000, h);
    chk("R7 held low count", h, 0);
    setup(16'h003F, 1, 0, 1);
    sweep("R7 below range carrier256", 16'h003F, 1, 0, 1, 1000, h);
    setup(16'h0040, 1, 0, 1);
    sweep("R5 lowest legal carrier256", 16'h0040, 1, 0, 1, 1000, h);

    // R10: output enable cleared
    setup(16'h2000, 0, 0, 0);
    sweep("R10 output disabled", 16'h2000, 0, 0, 0, 2000, h);
    chk("R10 no high ticks", h, 0);

    // R9: mid-period change applies only after the wrap
    setup(16'h0123, 1, 0, 1);
    h = 0;
    for (int k = 0; k < 16384 + 2000; k++) begin
      if (k < 16384) begin
        chk("R9 old setting held", pwmOut, expOut(k, 16'h0123, 1, 0, 1));
        h += pwmOut;
      end else begin
        chk("R9 new setting after wrap", pwmOut, expOut(k, 16'h0A81, 0, 0, 1));
      end
      if (k == 5000) begin
        wrEn = 1'b1; regSlot = 1'b0; wrData = {3'b110, 11'b0, 1'b1, 1'b0};
      end else if (k == 5001) begin
        wrData = {14'h0A81, 1'b0, 1'b1};
      end else if (k == 5002) begin
        wrEn = 1'b0;
      end
      @(negedge clk);
    end
    chk("R9 R6 old period total", h, 16'h0123);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule